// File: doc/BRIEF.md
# Register-Mapped Serial Port with Atomic Bit Aliases

This block is a byte-oriented asynchronous serial port behind a small register bus. Software sets a divisor, turns on the port and its two directions, and then exchanges bytes through a transmit register and a receive register. Each direction has an 8-entry queue. Frames are always one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Timing comes from a shared tick that fires once every divisor+1 clocks, and every bit lasts 16 ticks.

The mode and status registers each have two extra addresses. Writing a 1 at the set address turns the matching bits on. Writing a 1 at the clear address turns them off. All other bits keep their value, so software can change one control bit without a read-modify-write. A receive overrun is sticky and shuts the receiver off until software clears it. On request the transmitter holds the line low as a break, starting once the frame in flight has ended.

Top module: `mmio_uart`

## Requirements
- R1: After reset the mode register reads 0, the status register (0x10) reads 0x0100 (only the transmit-empty bit 8 set), the divisor register reads 0, and the line output is high.
- R2: Mode (0x00) and status (0x10) are written directly at their base address. Writing a 1 at base+0x08 sets that bit and writing a 1 at base+0x04 clears it, with all other bits unchanged. Mode bit 15 is the port enable. Status bits 12, 11 and 10 are receive enable, break request and transmit enable.
- R3: The divisor register at 0x40 reads back what was written. Each bit on the line lasts (divisor+1)×16 clocks.
- R4: A byte written to 0x20 goes out as a start bit (low), data bits 0 to 7, and a stop bit (high).
- R5: The transmit queue holds 8 bytes. Status bit 9 is set while it is full, and a write to 0x20 while it is full is discarded.
- R6: Status bit 8 is 1 only when the transmit queue is empty and no frame or break is in progress.
- R7: A received frame with a high stop bit is queued and sets status bit 0. A read of 0x30 returns the oldest byte in bits 7:0 and removes it from the queue.
- R8: A low pulse on the input that is gone before the middle of the start bit produces no byte.
- R9: A frame that completes while the receive queue holds 8 bytes is dropped and sets status bit 1. While bit 1 is set, the receiver ignores all frames. Only a 1 written to bit 1 at 0x14 clears it.
- R10: While status bit 11 is set, the transmitter finishes the current frame and then drives the line low until the bit is cleared.
- R11: While mode bit 15 is 0, nothing is transmitted and the line stays high, even if bytes are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench keeps the default queue depth of 8 and a 16-bit bus, and programs a divisor of 2, so one bit lasts 48 clocks. With a bit that short, the bench can fill a queue, overrun it, hold a break and clear it again, all within a few thousand cycles. A loopback from the output to the input lets the transmit and receive paths check each other across a full queue. The exact 48-clock start bit shows that the divisor counts divisor+1 clocks per tick rather than divisor clocks.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] A_MODE   = 8'h00;
    localparam logic [REG_AW-1:0] A_STAT   = 8'h10;
    localparam logic [REG_AW-1:0] A_TXDATA = 8'h20;
    localparam logic [REG_AW-1:0] A_RXDATA = 8'h30;
    localparam logic [REG_AW-1:0] A_DIV    = 8'h40;
    localparam logic [REG_AW-1:0] OFS_CLR  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_SET  = 8'h08;

    localparam int BP_EN     = 15;
    localparam int BP_RXEN   = 12;
    localparam int BP_BRK    = 11;
    localparam int BP_TXEN   = 10;
    localparam int BP_TXFULL = 9;
    localparam int BP_TXIDLE = 8;
    localparam int BP_OVR    = 1;
    localparam int BP_RXAV   = 0;

    localparam int FRAME_BITS = 8;
    localparam int OVS        = 16;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        WK_NONE, WK_PLAIN, WK_SET, WK_CLR
    } wkind_e;

    typedef struct packed {
        logic rx_en;
        logic brk;
        logic tx_en;
        logic ovr;
    } stat_ctl_t;

    function automatic wkind_e decode_wr(logic wr, logic [REG_AW-1:0] a,
                                         logic [REG_AW-1:0] base);
        if (!wr)                 return WK_NONE;
        if (a == base)           return WK_PLAIN;
        if (a == base + OFS_SET) return WK_SET;
        if (a == base + OFS_CLR) return WK_CLR;
        return WK_NONE;
    endfunction

    function automatic logic apply_bit(logic cur, wkind_e k, logic b);
        case (k)
            WK_PLAIN: return b;
            WK_SET:   return cur | b;
            WK_CLR:   return cur & ~b;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            end
            if (do_pop)
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mmio_uart_baud.sv
module mmio_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         send_ok,
    input  logic         brk,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    output logic         q_pop,
    output logic         line,
    output logic         idle
);
    localparam int BW = $clog2(W);
    localparam int TW = $clog2(OVS);

    tx_state_e     st;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bitn;
    logic [W-1:0]  sh;
    logic          last_tick;

    assign last_tick = tick && (tcnt == TW'(OVS - 1));
    assign q_pop     = run && (st == TX_IDLE) && tick && !brk && send_ok && !q_empty;
    assign idle      = (st == TX_IDLE);

    always_comb begin
        case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh[0];
            TX_BREAK: line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st   <= TX_IDLE;
            tcnt <= '0;
            bitn <= '0;
            sh   <= '0;
        end else begin
            if (tick && st != TX_IDLE && st != TX_BREAK)
                tcnt <= tcnt + TW'(1);
            case (st)
                TX_IDLE: begin
                    tcnt <= '0;
                    if (tick && brk)
                        st <= TX_BREAK;
                    else if (q_pop) begin
                        sh <= q_data;
                        st <= TX_START;
                    end
                end
                TX_START: if (last_tick) begin
                    st   <= TX_DATA;
                    bitn <= '0;
                end
                TX_DATA: if (last_tick) begin
                    sh <= sh >> 1;
                    if (bitn == BW'(W - 1))
                        st <= TX_STOP;
                    else
                        bitn <= bitn + BW'(1);
                end
                TX_STOP:  if (last_tick) st <= TX_IDLE;
                TX_BREAK: if (!brk) st <= TX_IDLE;
                default:  st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
    import mmio_uart_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         line_in,
    output logic         push,
    output logic [W-1:0] data
);
    localparam int BW = $clog2(W);
    localparam int TW = $clog2(OVS);

    rx_state_e     st;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bitn;
    logic [W-1:0]  sh;
    logic [1:0]    sync;
    logic          s;

    assign s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], line_in};
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st   <= RX_IDLE;
            tcnt <= '0;
            bitn <= '0;
            sh   <= '0;
            push <= 1'b0;
            data <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: if (!s) begin
                        st   <= RX_START;
                        tcnt <= '0;
                    end
                    RX_START: begin
                        if (tcnt == TW'(OVS / 2 - 1)) begin
                            tcnt <= '0;
                            bitn <= '0;
                            st   <= s ? RX_IDLE : RX_DATA;
                        end else
                            tcnt <= tcnt + TW'(1);
                    end
                    RX_DATA: begin
                        tcnt <= tcnt + TW'(1);
                        if (tcnt == TW'(OVS - 1)) begin
                            sh <= {s, sh[W-1:1]};
                            if (bitn == BW'(W - 1))
                                st <= RX_STOP;
                            else
                                bitn <= bitn + BW'(1);
                        end
                    end
                    RX_STOP: begin
                        tcnt <= tcnt + TW'(1);
                        if (tcnt == TW'(OVS - 1)) begin
                            push <= s;
                            data <= sh;
                            st   <= RX_IDLE;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int DIV_W  = 16,
    parameter int QDEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    localparam int W = FRAME_BITS;

    logic             mode_en;
    stat_ctl_t        ctl;
    logic [DIV_W-1:0] div;
    logic             wr, rd;
    wkind_e           mk, sk;

    logic             tick;
    logic             tx_push, tx_pop, tx_full, tx_qempty, tx_idle, tx_empty;
    logic [W-1:0]     tx_qdata;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [W-1:0]     rx_data, rx_dout;
    logic             rx_run;

    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && !bus_wr;
    assign mk = decode_wr(wr, bus_addr, A_MODE);
    assign sk = decode_wr(wr, bus_addr, A_STAT);

    assign tx_push  = wr && (bus_addr == A_TXDATA);
    assign rx_pop   = rd && (bus_addr == A_RXDATA);
    assign tx_empty = tx_qempty && tx_idle;
    assign rx_run   = mode_en && ctl.rx_en && !ctl.ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en <= 1'b0;
            ctl     <= '0;
            div     <= '0;
        end else begin
            mode_en   <= apply_bit(mode_en, mk, bus_wdata[BP_EN]);
            ctl.rx_en <= apply_bit(ctl.rx_en, sk, bus_wdata[BP_RXEN]);
            ctl.brk   <= apply_bit(ctl.brk, sk, bus_wdata[BP_BRK]);
            ctl.tx_en <= apply_bit(ctl.tx_en, sk, bus_wdata[BP_TXEN]);
            if (rx_push && rx_full)
                ctl.ovr <= 1'b1;
            else if (sk == WK_CLR && bus_wdata[BP_OVR])
                ctl.ovr <= 1'b0;
            if (wr && bus_addr == A_DIV)
                div <= bus_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: bus_rdata[BP_EN] = mode_en;
            A_STAT: begin
                bus_rdata[BP_RXEN]   = ctl.rx_en;
                bus_rdata[BP_BRK]    = ctl.brk;
                bus_rdata[BP_TXEN]   = ctl.tx_en;
                bus_rdata[BP_TXFULL] = tx_full;
                bus_rdata[BP_TXIDLE] = tx_empty;
                bus_rdata[BP_OVR]    = ctl.ovr;
                bus_rdata[BP_RXAV]   = !rx_empty;
            end
            A_RXDATA: bus_rdata[W-1:0]     = rx_dout;
            A_DIV:    bus_rdata[DIV_W-1:0] = div;
            default:  bus_rdata = '0;
        endcase
    end

    mmio_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(mode_en), .div(div), .tick(tick)
    );

    mmio_uart_fifo #(.DEPTH(QDEPTH), .W(W)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
        .din(bus_wdata[W-1:0]), .dout(tx_qdata),
        .full(tx_full), .empty(tx_qempty)
    );

    mmio_uart_tx #(.W(W)) u_tx (
        .clk(clk), .rst(rst), .run(mode_en), .tick(tick),
        .send_ok(ctl.tx_en), .brk(ctl.brk),
        .q_empty(tx_qempty), .q_data(tx_qdata), .q_pop(tx_pop),
        .line(txd), .idle(tx_idle)
    );

    mmio_uart_rx #(.W(W)) u_rx (
        .clk(clk), .rst(rst), .run(rx_run), .tick(tick),
        .line_in(rxd), .push(rx_push), .data(rx_data)
    );

    mmio_uart_fifo #(.DEPTH(QDEPTH), .W(W)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
        .din(rx_data), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk
    import mmio_uart_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              txd,
    input logic              mode_en,
    input logic              ovr,
    input logic              rx_push,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              tx_push,
    input logic              tx_pop
);
    logic mode_set_hit, mode_clr_hit, ovr_clr_hit;

    assign mode_set_hit = bus_sel && bus_wr && bus_addr == (A_MODE + OFS_SET) && bus_wdata[BP_EN];
    assign mode_clr_hit = bus_sel && bus_wr && bus_addr == (A_MODE + OFS_CLR) && bus_wdata[BP_EN];
    assign ovr_clr_hit  = bus_sel && bus_wr && bus_addr == (A_STAT + OFS_CLR) && bus_wdata[BP_OVR];

    a_r2_set_alias: assert property (@(posedge clk) disable iff (rst)
        mode_set_hit |=> mode_en);

    a_r2_clr_alias: assert property (@(posedge clk) disable iff (rst)
        mode_clr_hit |=> !mode_en);

    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !tx_pop) |=> tx_full);

    a_r6_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr_hit) |=> ovr);

    a_r9_no_push_while_ovr: assert property (@(posedge clk) disable iff (rst)
        ovr |-> !rx_push);

    a_r11_disabled_line_high: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> txd);
endmodule

bind mmio_uart mmio_uart_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .txd(txd),
    .mode_en(mode_en), .ovr(ctl.ovr), .rx_push(rx_push),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_push(tx_push), .tx_pop(tx_pop)
);

// File: tb/test_mmio_uart.sv
module test_mmio_uart;
    localparam int BUS_W = 16;
    localparam int DIVV  = 2;
    localparam int P     = 16 * (DIVV + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic             rxd, txd;
    logic             lb = 1'b0;
    logic             rxd_drv = 1'b1;

    int checks = 0;
    int errors = 0;

    assign rxd = lb ? txd : rxd_drv;

    always #4 clk = ~clk;

    mmio_uart i_mmio_uart (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    // {write, address, data or expected read value}
    localparam logic [40:0] VEC [15] = '{
        {1'b1, 8'h00, 32'h0000}, {1'b1, 8'h08, 32'h8000}, {1'b0, 8'h00, 32'h8000},
        {1'b1, 8'h04, 32'h8000}, {1'b0, 8'h00, 32'h0000}, {1'b1, 8'h18, 32'h1000},
        {1'b0, 8'h10, 32'h1100}, {1'b1, 8'h18, 32'h0400}, {1'b0, 8'h10, 32'h1500},
        {1'b1, 8'h14, 32'h1000}, {1'b0, 8'h10, 32'h0500}, {1'b1, 8'h40, 32'h1234},
        {1'b0, 8'h40, 32'h1234}, {1'b1, 8'h40, 32'h0002}, {1'b0, 8'h40, 32'h0002}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_fall(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin seen = 1'b1; break; end
        end
    endtask

    task automatic capture(output logic [7:0] b, output logic stop);
        bit seen;
        wait_fall(seen);
        repeat (P / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (P) @(negedge clk);
            b[i] = txd;
        end
        repeat (P) @(negedge clk);
        stop = txd;
    endtask

    task automatic send(input logic [7:0] b);
        rxd_drv = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = b[i];
            repeat (P) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (2 * P) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] d;
        logic [7:0] b;
        logic stop;
        bit seen, hi_ok;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); check(d == 16'h0000, "R1 mode", d, 16'h0000);
        rd(8'h10, d); check(d == 16'h0100, "R1 status", d, 16'h0100);
        rd(8'h40, d); check(d == 16'h0000, "R1 divisor", d, 0);
        check(txd == 1'b1, "R1 line", txd, 1);

        // R2 / R3 alias and register table
        foreach (VEC[i]) begin
            if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][15:0]);
            else begin
                rd(VEC[i][39:32], d);
                check(d == VEC[i][15:0], "R2 alias vector", d, VEC[i][15:0]);
            end
        end

        // R5 R6 R11 queue fill while port disabled
        wr(8'h18, 16'h1000);
        wr(8'h20, 16'h00A0);
        rd(8'h10, d); check(d[8] == 1'b0, "R6 not empty with queued byte", d[8], 0);
        for (int i = 1; i < 8; i++) wr(8'h20, 16'h00A0 + i[15:0]);
        rd(8'h10, d); check(d[9] == 1'b1, "R5 full after 8", d[9], 1);
        wr(8'h20, 16'h00EE);
        hi_ok = 1'b1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (txd != 1'b1) hi_ok = 1'b0;
        end
        check(hi_ok, "R11 line high while disabled", hi_ok, 1);

        // R4 R5 R7 loopback of full queue
        lb = 1'b1;
        wr(8'h08, 16'h8000);
        n = 0;
        do begin rd(8'h10, d); n++; end while (d[8] == 1'b0 && n < 8000);
        check(d[8] == 1'b1, "R6 empty after drain", d[8], 1);
        repeat (100) @(negedge clk);
        rd(8'h10, d);
        check(d[0] == 1'b1 && d[1] == 1'b0, "R7 data available, no overrun", d[1:0], 1);
        for (int i = 0; i < 8; i++) begin
            rd(8'h30, d);
            check(d == 16'h00A0 + i[15:0], "R7 loopback byte order", d, 16'h00A0 + i);
        end
        rd(8'h10, d); check(d[0] == 1'b0, "R5 ninth byte discarded", d[0], 0);
        lb = 1'b0;

        // R3 bit period
        wr(8'h20, 16'h0001);
        wait_fall(seen);
        n = 0;
        while (txd == 1'b0 && n < 1000) begin n++; @(negedge clk); end
        check(n == P, "R3 start bit length", n, P);
        repeat (600) @(negedge clk);

        // R4 frame
        wr(8'h20, 16'h00C5);
        capture(b, stop);
        check(b == 8'hC5, "R4 data bits lsb first", b, 8'hC5);
        check(stop == 1'b1, "R4 stop bit", stop, 1);
        repeat (P) @(negedge clk);

        // R8 glitch
        rxd_drv = 1'b0;
        repeat (4) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (600) @(negedge clk);
        rd(8'h10, d); check(d[0] == 1'b0, "R8 glitch rejected", d[0], 0);
        send(8'h3C);
        rd(8'h30, d); check(d == 16'h003C, "R7 driven byte", d, 16'h003C);

        // R9 overrun
        for (int i = 0; i < 8; i++) send(8'h10 + i[7:0]);
        send(8'h99);
        rd(8'h10, d); check(d[1] == 1'b1, "R9 overrun set", d[1], 1);
        send(8'h77);
        for (int i = 0; i < 8; i++) begin
            rd(8'h30, d);
            check(d == 16'h0010 + i[15:0], "R9 queued bytes kept", d, 16'h0010 + i);
        end
        rd(8'h10, d); check(d[0] == 1'b0 && d[1] == 1'b1, "R9 frames ignored while set", d[1:0], 2);
        wr(8'h10, 16'h1400);
        rd(8'h10, d); check(d[1] == 1'b1, "R9 plain write keeps overrun", d[1], 1);
        wr(8'h14, 16'h0002);
        rd(8'h10, d); check(d[1] == 1'b0, "R9 cleared by clear alias", d[1], 0);
        send(8'h42);
        rd(8'h30, d); check(d == 16'h0042, "R9 reception resumes", d, 16'h0042);

        // R10 break
        wr(8'h20, 16'h00FF);
        wait_fall(seen);
        wr(8'h18, 16'h0800);
        repeat (P * 9 + P / 2 - 2) @(negedge clk);
        check(txd == 1'b1, "R10 frame completes before break", txd, 1);
        repeat (2 * P) @(negedge clk);
        check(txd == 1'b0, "R10 line held low", txd, 0);
        rd(8'h10, d); check(d[8] == 1'b0, "R6 not empty during break", d[8], 0);
        wr(8'h14, 16'h0800);
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R10 line released", txd, 1);
        rd(8'h10, d); check(d[8] == 1'b1, "R6 empty after break", d[8], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule